// File: doc/BRIEF.md
# Reset Cause Recorder

This block gathers every reset request of a small microcontroller into one system reset and records why that reset happened. The requests are power-on detect, an active-low external reset pin, a watchdog timeout that an enable input can block, an illegal-opcode request, an illegal-address request, a low-voltage detect and a reset forced by a debug host. Two CPU conditions also raise the illegal-opcode request: a STOP attempt while stop is disabled, and a background-entry attempt while background debug is disabled.

A three-state machine drives the merged reset. **RUN** is normal operation. **HOLD** means at least one request is active. **STRETCH** counts quiet cycles after the last request goes away. Transitions: RUN→HOLD on any request (reset entry, the status is captured here). HOLD→STRETCH when every request is gone. STRETCH→HOLD when a request returns. STRETCH→RUN after the last quiet cycle. Power-on detect is asynchronous and forces HOLD directly.

The cause register is read-only and is always visible on the read port. A bus write to its address leaves it as it is and instead produces a watchdog-clear pulse.

Top module: `rst_cause_rec`

## Requirements
- R1: Read data always shows the cause register. Bit 7 is power-on, bit 6 is external pin, bit 5 is watchdog, bit 4 is illegal opcode, bit 3 is illegal address and bit 1 is low voltage. Bits 2 and 0 always read 0.
- R2: On the first clock edge of reset entry (the RUN→HOLD edge), each active source sets its bit and each inactive source clears its bit. The register then holds its value, through the rest of the reset and afterwards, until the next entry. A new request during HOLD or STRETCH does not change it.
- R3: Asserting `por_req` immediately sets `sys_rst` to 1 and the register to 0x82.
- R4: An entry with low voltage active sets bit 1 and keeps bit 7 at its previous value. The other cause bits follow R2.
- R5: An entry caused only by the debug force sets no bit (the register reads 0x00) and still asserts `sys_rst`.
- R6: A watchdog timeout is a reset source only while `wdog_en` is 1. With `wdog_en` at 0 it causes no reset and no change to the register.
- R7: The illegal-opcode source is active when `illop_req` is 1, when `stop_exec` is 1 with `stop_en` at 0, or when `bgnd_exec` is 1 with `bgnd_en` at 0. An enabled STOP or background attempt causes no reset.
- R8: The external pin passes through a two-flop synchronizer. If the pin falls between two edges, `sys_rst` rises after the third edge following the fall.
- R9: `sys_rst` is 1 whenever a request is active. After the last synchronized request is released, `sys_rst` stays 1 for 16 more clock edges, so it falls 17 edges after the first quiet edge. A request during the stretch restarts the count.
- R10: `wdog_clr` is 1 in exactly the cycles where `bus_wr` and `bus_sel` are both 1. The write leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdog_timeout | input | 1 | Watchdog timeout request |
| wdog_en | input | 1 | Watchdog enable; 0 blocks the timeout |
| illop_req | input | 1 | Illegal-opcode request from the decoder |
| stop_exec | input | 1 | STOP execution attempt |
| stop_en | input | 1 | STOP permitted |
| bgnd_exec | input | 1 | Background-entry execution attempt |
| bgnd_en | input | 1 | Background debug permitted |
| illadr_req | input | 1 | Illegal-address request |
| lvd_req | input | 1 | Low-voltage detect request |
| dbg_force | input | 1 | Debug-host forced reset |
| bus_sel | input | 1 | Bus access targets the cause register |
| bus_wr | input | 1 | Bus write strobe |
| rd_data | output | 8 | Cause register read data |
| wdog_clr | output | 1 | Watchdog-clear pulse |
| sys_rst | output | 1 | Merged system reset, active high |

## Verification
The bench aims at the power-on bit under two low-voltage entries: one straight after power-on and one after another cause has cleared it. A design that clears the bit, or sets it unconditionally, shows 0x02 or 0x82 at the wrong time. It measures the stretch length exactly. It also checks the extra two cycles the synchronizer adds on both pin edges, and a request that arrives mid-stretch, which must restart the count without recapturing the causes. It also fires blocked sources: watchdog with the enable low, and STOP or background with permission granted. A design that gates these wrongly resets when it should not, or misses the illegal-opcode cause.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STRETCH = 2'd2
    } rst_state_e;

    localparam int BIT_POR  = 7;
    localparam int BIT_PIN  = 6;
    localparam int BIT_WDG  = 5;
    localparam int BIT_ILOP = 4;
    localparam int BIT_ILAD = 3;
    localparam int BIT_LVD  = 1;

    localparam logic [7:0] STAT_POR_VAL = 8'h82;

    typedef struct packed {
        logic pin;
        logic wdg;
        logic ilop;
        logic ilad;
        logic lvd;
        logic dbg;
    } rst_src_t;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_req,
    input  logic pin_n,
    output logic pin_act
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) sh <= '1;
        else         sh <= {sh[STAGES-2:0], pin_n};
    end

    assign pin_act = ~sh[STAGES-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_cause_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic por_req,
    input  logic any_req,
    output logic entry,
    output logic sys_rst
);
    localparam int CNT_W = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH_CYC - 1);

    rst_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_RUN: if (any_req) state_nx = ST_HOLD;
            ST_HOLD: if (!any_req) begin
                state_nx = ST_STRETCH;
                cnt_nx   = '0;
            end
            ST_STRETCH: begin
                if (any_req)              state_nx = ST_HOLD;
                else if (cnt == CNT_LAST) state_nx = ST_RUN;
                else                      cnt_nx   = cnt + 1'b1;
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        entry   = (state == ST_RUN) && any_req;
        sys_rst = (state != ST_RUN);
    end

    a_r9_req_holds_rst: assert property (@(posedge clk) disable iff (por_req)
        any_req |=> sys_rst);

    a_r9_release_quiet: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> !$past(any_req));
endmodule

// File: rtl/rst_status_reg.sv
module rst_status_reg
    import rst_cause_pkg::*;
(
    input  logic       clk,
    input  logic       por_req,
    input  logic       entry,
    input  rst_src_t   src,
    output logic [7:0] status
);
    logic [7:0] cap;

    always_comb begin
        cap           = '0;
        cap[BIT_POR]  = src.lvd & status[BIT_POR];
        cap[BIT_PIN]  = src.pin;
        cap[BIT_WDG]  = src.wdg;
        cap[BIT_ILOP] = src.ilop;
        cap[BIT_ILAD] = src.ilad;
        cap[BIT_LVD]  = src.lvd;
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req)    status <= STAT_POR_VAL;
        else if (entry) status <= cap;
    end

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (por_req)
        !entry |=> $stable(status));

    a_r4_por_kept: assert property (@(posedge clk) disable iff (por_req)
        (entry && src.lvd) |=> (status[BIT_POR] == $past(status[BIT_POR])));

    a_r5_dbg_only: assert property (@(posedge clk) disable iff (por_req)
        (entry && src.dbg && !(src.pin || src.wdg || src.ilop || src.ilad || src.lvd))
        |=> (status == 8'h00));
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import rst_cause_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH_CYC = 16
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       ext_rst_n,
    input  logic       wdog_timeout,
    input  logic       wdog_en,
    input  logic       illop_req,
    input  logic       stop_exec,
    input  logic       stop_en,
    input  logic       bgnd_exec,
    input  logic       bgnd_en,
    input  logic       illadr_req,
    input  logic       lvd_req,
    input  logic       dbg_force,
    input  logic       bus_sel,
    input  logic       bus_wr,
    output logic [7:0] rd_data,
    output logic       wdog_clr,
    output logic       sys_rst
);
    logic     pin_act;
    logic     entry;
    logic     any_req;
    rst_src_t src;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .por_req (por_req),
        .pin_n   (ext_rst_n),
        .pin_act (pin_act)
    );

    always_comb begin
        src.pin  = pin_act;
        src.wdg  = wdog_timeout & wdog_en;
        src.ilop = illop_req | (stop_exec & ~stop_en) | (bgnd_exec & ~bgnd_en);
        src.ilad = illadr_req;
        src.lvd  = lvd_req;
        src.dbg  = dbg_force;
        any_req  = |src;
    end

    rst_seq_fsm #(.STRETCH_CYC(STRETCH_CYC)) u_fsm (
        .clk     (clk),
        .por_req (por_req),
        .any_req (any_req),
        .entry   (entry),
        .sys_rst (sys_rst)
    );

    rst_status_reg u_stat (
        .clk     (clk),
        .por_req (por_req),
        .entry   (entry),
        .src     (src),
        .status  (rd_data)
    );

    assign wdog_clr = bus_wr & bus_sel;

    a_r10_write_keeps: assert property (@(posedge clk) disable iff (por_req)
        (wdog_clr && !entry) |=> $stable(rd_data));
endmodule

// File: tb/rst_cause_rec_tb.sv
module rst_cause_rec_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic por_req = 1'b1, ext_rst_n = 1'b1, wdog_timeout = 1'b0, wdog_en = 1'b1;
    logic illop_req = 1'b0, stop_exec = 1'b0, stop_en = 1'b1;
    logic bgnd_exec = 1'b0, bgnd_en = 1'b1, illadr_req = 1'b0, lvd_req = 1'b0;
    logic dbg_force = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] rd_data;
    logic wdog_clr, sys_rst;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    rst_cause_rec u_dut (
        .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n),
        .wdog_timeout(wdog_timeout), .wdog_en(wdog_en), .illop_req(illop_req),
        .stop_exec(stop_exec), .stop_en(stop_en), .bgnd_exec(bgnd_exec),
        .bgnd_en(bgnd_en), .illadr_req(illadr_req), .lvd_req(lvd_req),
        .dbg_force(dbg_force), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .rd_data(rd_data), .wdog_clr(wdog_clr), .sys_rst(sys_rst)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: quiet-edge counter and pin history
    bit         m_rst;
    int         m_quiet;
    logic [7:0] m_stat;
    logic       p1, p2;
    always @(posedge clk or posedge por_req) begin
        if (por_req) begin
            m_rst = 1'b1; m_stat = 8'h82; m_quiet = 0; p1 = 1'b1; p2 = 1'b1;
        end else begin
            logic pin_now, cop, ilop, any;
            pin_now = !p2; p2 = p1; p1 = ext_rst_n;
            cop  = wdog_timeout && wdog_en;
            ilop = illop_req || (stop_exec && !stop_en) || (bgnd_exec && !bgnd_en);
            any  = pin_now || cop || ilop || illadr_req || lvd_req || dbg_force;
            if (!m_rst) begin
                if (any) begin
                    m_rst = 1'b1; m_quiet = 0;
                    m_stat = {lvd_req & m_stat[7], pin_now, cop, ilop, illadr_req, 1'b0, lvd_req, 1'b0};
                end
            end else if (any) m_quiet = 0;
            else begin
                m_quiet++;
                if (m_quiet == 17) begin m_rst = 1'b0; m_quiet = 0; end
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk("R9 sys_rst model", int'(sys_rst), int'(m_rst));
            chk("R2 status model", int'(rd_data), int'(m_stat));
            chk("R10 wdog_clr model", int'(wdog_clr), int'(bus_wr & bus_sel));
            chk("R1 fixed zero bits", int'({rd_data[2], rd_data[0]}), 0);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(string req, int exp);
        int n = 0;
        while (sys_rst && n < 100) begin tick(); n++; end
        chk(req, n, exp);
    endtask

    initial begin
        tick(3);
        chk("R3 por sys_rst", int'(sys_rst), 1);
        chk("R3 por status", int'(rd_data), 8'h82);
        por_req = 1'b0;
        wait_idle("R9 stretch after por", 17);

        bus_sel = 1'b1; bus_wr = 1'b1; #1;
        chk("R10 clear pulse", int'(wdog_clr), 1);
        tick(); bus_sel = 1'b0; bus_wr = 1'b0; #1;
        chk("R10 clear ends", int'(wdog_clr), 0);
        chk("R10 status kept", int'(rd_data), 8'h82);

        lvd_req = 1'b1; tick(); lvd_req = 1'b0;
        chk("R4 lvd keeps por bit", int'(rd_data), 8'h82);
        wait_idle("R9 stretch lvd", 17);

        illadr_req = 1'b1; tick(); illadr_req = 1'b0;
        chk("R2 illegal address", int'(rd_data), 8'h08);
        wait_idle("R9 stretch illadr", 17);

        lvd_req = 1'b1; tick(); lvd_req = 1'b0;
        chk("R4 lvd with por clear", int'(rd_data), 8'h02);
        wait_idle("R9 stretch lvd2", 17);

        wdog_en = 1'b0; wdog_timeout = 1'b1; tick(3);
        chk("R6 blocked no reset", int'(sys_rst), 0);
        chk("R6 blocked status", int'(rd_data), 8'h02);
        wdog_en = 1'b1; tick(); wdog_timeout = 1'b0;
        chk("R6 enabled watchdog", int'(rd_data), 8'h20);
        wait_idle("R9 stretch wdog", 17);

        stop_exec = 1'b1; tick(2);
        chk("R7 stop allowed", int'(sys_rst), 0);
        stop_en = 1'b0; tick(); stop_exec = 1'b0; stop_en = 1'b1;
        chk("R7 stop disabled", int'(rd_data), 8'h10);
        wait_idle("R9 stretch stop", 17);

        dbg_force = 1'b1; tick(); dbg_force = 1'b0;
        chk("R5 dbg reset asserted", int'(sys_rst), 1);
        chk("R5 dbg status", int'(rd_data), 8'h00);
        wait_idle("R9 stretch dbg", 17);

        bgnd_exec = 1'b1; tick(2);
        chk("R7 bgnd allowed", int'(sys_rst), 0);
        bgnd_en = 1'b0; tick(); bgnd_exec = 1'b0; bgnd_en = 1'b1;
        chk("R7 bgnd disabled", int'(rd_data), 8'h10);
        wait_idle("R9 stretch bgnd", 17);

        ext_rst_n = 1'b0; tick();
        chk("R8 sync edge1", int'(sys_rst), 0);
        tick();
        chk("R8 sync edge2", int'(sys_rst), 0);
        tick(); ext_rst_n = 1'b1;
        chk("R8 sync edge3", int'(sys_rst), 1);
        chk("R8 pin status", int'(rd_data), 8'h40);
        wait_idle("R8 R9 pin release", 19);

        illop_req = 1'b1; illadr_req = 1'b1; lvd_req = 1'b1; tick();
        illop_req = 1'b0; illadr_req = 1'b0; lvd_req = 1'b0;
        chk("R2 combined causes", int'(rd_data), 8'h1A);
        wait_idle("R9 stretch combined", 17);

        illadr_req = 1'b1; tick(); illadr_req = 1'b0; tick(8);
        illop_req = 1'b1; tick(); illop_req = 1'b0;
        chk("R2 no recapture", int'(rd_data), 8'h08);
        chk("R9 restart asserted", int'(sys_rst), 1);
        wait_idle("R9 restart stretch", 17);

        tick(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog R9 actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule